// File: doc/BRIEF.md
# Clock Ratio Unit

This block turns one fast synthesis clock into the processor, bus, 48 MHz, reference and interrupt-controller clock lines of a desktop clock generator. A three-bit select code picks one of four behaviours. The first is a quiet state in which every group is released to high impedance. The second and third are two running states in which the processor clock runs at 66 MHz or 100 MHz and the bus clock stays at 33 MHz. The fourth is a production test state in which the dividers step on an externally driven test clock instead of the synthesis clock.

All logic runs on the synthesis clock, which is twice the processor rate. The test clock and the 48 MHz source arrive as slow levels and are sampled. In the test state, each sampled rising edge of the test clock advances the dividers by one step. Every group has its own registered output enable, which the pad ring uses to release the lines. Clock stopping and power-down gating sit in a neighbouring block and are not part of this unit.

Top module: `clock_ratio_unit`

## Requirements
- R1: The select code `sel_code` is read as {speed bit, bit1, bit0}. 3'b011 selects the 66 MHz state, 3'b111 the 100 MHz state, 3'b100 the test state, and 3'b000 the quiet state.
- R2: In the quiet state (3'b000), all five group enables are 0 from the first clock edge that samples the code. Every clock line is also held at 0, whatever `tclk_in` and `aux48_in` do.
- R3: The unassigned codes 3'b001, 3'b010, 3'b101 and 3'b110 behave exactly like 3'b000.
- R4: For any of the three active codes, all five group enables are 1 from the first clock edge that samples the code.
- R5: In the 66 MHz and 100 MHz states, the processor outputs toggle on every synthesis clock edge, which divides that clock by 2.
- R6: In the 100 MHz state, the bus outputs and the free-running bus output divide the synthesis clock by 6, high for 3 cycles and low for 3. Every rising edge of the bus clock coincides with a rising edge of the processor clock.
- R7: In the 66 MHz state, the bus outputs divide the synthesis clock by 4, high for 2 cycles and low for 2.
- R8: In the test state, the dividers advance once per rising edge of `tclk_in`. An edge is detected from two successive samples and acted on one edge later. The processor lines divide the test clock by 2, the bus lines by 6 and the 48 MHz lines by 2.
- R9: In every active state, the reference and interrupt-controller lines show the value `tclk_in` had at the previous synthesis clock edge, without division.
- R10: In the 66 MHz and 100 MHz states, the 48 MHz lines show the value `aux48_in` had at the previous synthesis clock edge.
- R11: Any change of the select code clears every divider on the first edge that sees the new code. All divided lines then start high together.
- R12: While `rst_n` is low, every enable and every clock line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | synthesis clock, twice the processor rate |
| rst_n | input | 1 | asynchronous active-low reset |
| sel_code | input | 3 | frequency and mode select code |
| tclk_in | input | 1 | crystal or overdriven test clock level |
| aux48_in | input | 1 | 48 MHz source level used in the running states |
| cpu_clk_o | output | 4 | processor clock lines |
| pci_free_o | output | 1 | free-running bus clock line |
| pci_clk_o | output | 7 | bus clock lines |
| usb_clk_o | output | 2 | 48 MHz clock lines |
| ref_clk_o | output | 3 | reference clock lines |
| apic_clk_o | output | 2 | interrupt-controller clock lines |
| cpu_oe | output | 1 | enable for the processor group |
| pci_oe | output | 1 | enable for both bus groups |
| usb_oe | output | 1 | enable for the 48 MHz group |
| ref_oe | output | 1 | enable for the reference group |
| apic_oe | output | 1 | enable for the interrupt-controller group |

## Verification
The properties assume that `tclk_in` and `aux48_in` are slow levels held for at least two synthesis cycles, so that each test clock edge is seen exactly once. They also assume that the select code changes only between clock edges. The bench drives every input on the falling edge of `sys_clk` and holds each test clock phase for two cycles. Before it enters the test state, it keeps `tclk_in` low for at least two edges, so no stray edge is counted. The alignment property skips the edge that follows a restart, because a restart may raise the bus clock while the processor clock is already high.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  typedef enum logic [1:0] {
    MD_QUIET = 2'd0,
    MD_SLOW  = 2'd1,
    MD_FAST  = 2'd2,
    MD_TEST  = 2'd3
  } run_mode_e;

  localparam int SEL_W = 3;

  // output group indices for the enable vector
  localparam int GRP_CPU  = 0;
  localparam int GRP_PCI  = 1;
  localparam int GRP_USB  = 2;
  localparam int GRP_REF  = 3;
  localparam int GRP_APIC = 4;
  localparam int NGRP     = 5;

  // select code -> behaviour; anything unassigned is quiet
  function automatic run_mode_e decode_sel(input logic [SEL_W-1:0] code);
    case (code)
      3'b011:  return MD_SLOW;
      3'b111:  return MD_FAST;
      3'b100:  return MD_TEST;
      default: return MD_QUIET;
    endcase
  endfunction

  function automatic logic mode_live(input run_mode_e m);
    return m != MD_QUIET;
  endfunction

  function automatic logic mode_normal(input run_mode_e m);
    return (m == MD_SLOW) || (m == MD_FAST);
  endfunction

  // bus divider ratio for the current behaviour
  function automatic int unsigned pick_ratio(input run_mode_e m,
                                             input int unsigned r_slow,
                                             input int unsigned r_fast,
                                             input int unsigned r_test);
    case (m)
      MD_SLOW: return r_slow;
      MD_TEST: return r_test;
      default: return r_fast;
    endcase
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] ratio,
  output logic             level
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q >= (ratio - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // high for the first half of each period
  assign level = (cnt_q < (ratio >> 1));

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import clkratio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_code,
  output run_mode_e        mode_q,
  output logic [NGRP-1:0]  grp_oe,
  output logic             code_change
);

  logic [SEL_W-1:0] sel_q;
  run_mode_e        next_mode;

  assign next_mode   = decode_sel(sel_code);
  assign code_change = (sel_code != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= MD_QUIET;
    end else begin
      sel_q  <= sel_code;
      mode_q <= next_mode;
    end
  end

  // one enable flop per group so each pad group gets its own driver
  for (genvar g = 0; g < NGRP; g++) begin : g_oe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_oe[g] <= 1'b0;
      else        grp_oe[g] <= mode_live(next_mode);
    end
  end

endmodule

// File: rtl/edge_sampler.sv
module edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_in,
  input  logic aux_in,
  output logic tclk_lvl,
  output logic tclk_rise,
  output logic aux_lvl
);

  logic tclk_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_lvl  <= 1'b0;
      tclk_hist <= 1'b0;
      aux_lvl   <= 1'b0;
    end else begin
      tclk_lvl  <= tclk_in;
      tclk_hist <= tclk_lvl;
      aux_lvl   <= aux_in;
    end
  end

  assign tclk_rise = tclk_lvl & ~tclk_hist;

endmodule

// File: rtl/clock_ratio_unit.sv
module clock_ratio_unit
  import clkratio_pkg::*;
#(
  parameter int N_CPU        = 4,
  parameter int N_PCI        = 7,
  parameter int N_USB        = 2,
  parameter int N_REF        = 3,
  parameter int N_APIC       = 2,
  parameter int CPU_DIV      = 2,
  parameter int PCI_DIV_FAST = 6,
  parameter int PCI_DIV_SLOW = 4,
  parameter int PCI_DIV_TEST = 6,
  parameter int USB_DIV_TEST = 2
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic [2:0]        sel_code,
  input  logic              tclk_in,
  input  logic              aux48_in,
  output logic [N_CPU-1:0]  cpu_clk_o,
  output logic              pci_free_o,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic [N_USB-1:0]  usb_clk_o,
  output logic [N_REF-1:0]  ref_clk_o,
  output logic [N_APIC-1:0] apic_clk_o,
  output logic              cpu_oe,
  output logic              pci_oe,
  output logic              usb_oe,
  output logic              ref_oe,
  output logic              apic_oe
);

  localparam int unsigned MAX_DIV = max_of(max_of(CPU_DIV, USB_DIV_TEST),
                                           max_of(max_of(PCI_DIV_FAST, PCI_DIV_SLOW),
                                                  PCI_DIV_TEST));
  localparam int CNT_W = $clog2(MAX_DIV + 1);

  run_mode_e       mode_q;
  logic [NGRP-1:0] grp_oe;
  logic            code_change;
  logic            tclk_lvl;
  logic            tclk_rise;
  logic            aux_lvl;

  // named events for the checker
  logic            in_test;
  logic            live;
  logic            div_restart;
  logic            div_step;

  logic [CNT_W-1:0] pci_ratio;
  logic             cpu_lvl;
  logic             pci_lvl;
  logic             usb_div_lvl;
  logic             usb_lvl;

  mode_ctrl u_mode (
    .clk         (sys_clk),
    .rst_n       (rst_n),
    .sel_code    (sel_code),
    .mode_q      (mode_q),
    .grp_oe      (grp_oe),
    .code_change (code_change)
  );

  edge_sampler u_samp (
    .clk       (sys_clk),
    .rst_n     (rst_n),
    .tclk_in   (tclk_in),
    .aux_in    (aux48_in),
    .tclk_lvl  (tclk_lvl),
    .tclk_rise (tclk_rise),
    .aux_lvl   (aux_lvl)
  );

  assign in_test     = (mode_q == MD_TEST);
  assign live        = mode_live(mode_q);
  assign div_restart = code_change | ~live;
  assign div_step    = in_test ? tclk_rise : mode_normal(mode_q);
  assign pci_ratio   = CNT_W'(pick_ratio(mode_q, PCI_DIV_SLOW, PCI_DIV_FAST, PCI_DIV_TEST));

  ratio_div #(.CNT_W(CNT_W)) u_cpu_div (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .clear (div_restart),
    .step  (div_step),
    .ratio (CNT_W'(CPU_DIV)),
    .level (cpu_lvl)
  );

  ratio_div #(.CNT_W(CNT_W)) u_pci_div (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .clear (div_restart),
    .step  (div_step),
    .ratio (pci_ratio),
    .level (pci_lvl)
  );

  // 48 MHz divider only counts in test; the running states use the aux source
  ratio_div #(.CNT_W(CNT_W)) u_usb_div (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .clear (div_restart),
    .step  (in_test & tclk_rise),
    .ratio (CNT_W'(USB_DIV_TEST)),
    .level (usb_div_lvl)
  );

  assign usb_lvl = in_test ? usb_div_lvl : aux_lvl;

  assign cpu_clk_o  = {N_CPU{live & cpu_lvl}};
  assign pci_free_o = live & pci_lvl;
  assign pci_clk_o  = {N_PCI{live & pci_lvl}};
  assign usb_clk_o  = {N_USB{live & usb_lvl}};
  assign ref_clk_o  = {N_REF{live & tclk_lvl}};
  assign apic_clk_o = {N_APIC{live & tclk_lvl}};

  assign cpu_oe  = grp_oe[GRP_CPU];
  assign pci_oe  = grp_oe[GRP_PCI];
  assign usb_oe  = grp_oe[GRP_USB];
  assign ref_oe  = grp_oe[GRP_REF];
  assign apic_oe = grp_oe[GRP_APIC];

endmodule

// File: rtl/clkratio_chk.sv
module clkratio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel_code,
  input logic       tclk_in,
  input logic       cpu0,
  input logic       pci_free,
  input logic       ref0,
  input logic [4:0] oe_all,
  input logic       clk_any,
  input logic       restart,
  input logic       tclk_rise,
  input logic       in_test
);

  logic code_live;
  logic code_norm;
  assign code_live = (sel_code == 3'b011) || (sel_code == 3'b111) || (sel_code == 3'b100);
  assign code_norm = (sel_code == 3'b011) || (sel_code == 3'b111);

  // R2 and R3: quiet and unassigned codes release every group and hold lines low
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !code_live |=> (oe_all == 5'b00000) && !clk_any);

  assert_live_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_live |=> (oe_all == 5'b11111));

  assert_cpu_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_norm && (sel_code == $past(sel_code))) |=> (cpu0 != $past(cpu0)));

  assert_pci_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pci_free) && !$past(restart)) |-> $rose(cpu0));

  assert_test_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_test && !tclk_rise && !restart) |=> ($stable(cpu0) && $stable(pci_free)));

  assert_ref_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_live |=> (ref0 == $past(tclk_in)));

endmodule

bind clock_ratio_unit clkratio_chk u_chk (
  .clk       (sys_clk),
  .rst_n     (rst_n),
  .sel_code  (sel_code),
  .tclk_in   (tclk_in),
  .cpu0      (cpu_clk_o[0]),
  .pci_free  (pci_free_o),
  .ref0      (ref_clk_o[0]),
  .oe_all    ({cpu_oe, pci_oe, usb_oe, ref_oe, apic_oe}),
  .clk_any   (|{cpu_clk_o, pci_free_o, pci_clk_o, usb_clk_o, ref_clk_o, apic_clk_o}),
  .restart   (div_restart),
  .tclk_rise (tclk_rise),
  .in_test   (in_test)
);

// File: tb/tb_clock_ratio_unit.sv
module tb_clock_ratio_unit;

  localparam int CLK_P = 10;

  logic       sys_clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel_code;
  logic       tclk_in;
  logic       aux48_in;
  logic [3:0] cpu_clk_o;
  logic       pci_free_o;
  logic [6:0] pci_clk_o;
  logic [1:0] usb_clk_o;
  logic [2:0] ref_clk_o;
  logic [1:0] apic_clk_o;
  logic       cpu_oe, pci_oe, usb_oe, ref_oe, apic_oe;

  int checks = 0;
  int errs   = 0;

  always #(CLK_P/2) sys_clk = ~sys_clk;

  clock_ratio_unit dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .sel_code(sel_code),
    .tclk_in(tclk_in), .aux48_in(aux48_in),
    .cpu_clk_o(cpu_clk_o), .pci_free_o(pci_free_o), .pci_clk_o(pci_clk_o),
    .usb_clk_o(usb_clk_o), .ref_clk_o(ref_clk_o), .apic_clk_o(apic_clk_o),
    .cpu_oe(cpu_oe), .pci_oe(pci_oe), .usb_oe(usb_oe),
    .ref_oe(ref_oe), .apic_oe(apic_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] oes();
    return {cpu_oe, pci_oe, usb_oe, ref_oe, apic_oe};
  endfunction

  function automatic logic any_clk();
    return |{cpu_clk_o, pci_free_o, pci_clk_o, usb_clk_o, ref_clk_o, apic_clk_o};
  endfunction

  // apply a code at a falling edge; return at the first sample after it is taken
  task automatic set_code(input logic [2:0] c);
    sel_code = c;
    @(negedge sys_clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sel_code = 3'b111; tclk_in = 1'b1; aux48_in = 1'b1;
    repeat (3) @(negedge sys_clk);
    check("R12", "enables in reset", 32'(oes()), 32'h0);
    check("R12", "clocks in reset", 32'(any_clk()), 32'h0);
    sel_code = 3'b000; tclk_in = 1'b0; aux48_in = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge sys_clk);
    check("R2", "quiet after reset", 32'({oes(), any_clk()}), 32'h0);
  endtask

  // R1 R4 R5 R6: 100 MHz state pattern
  task automatic t_fast();
    set_code(3'b111);
    for (int j = 0; j < 12; j++) begin
      check("R4", "enables fast", 32'(oes()), 32'h1f);
      check("R5", "cpu fast", 32'(cpu_clk_o), (j % 2 == 0) ? 32'hf : 32'h0);
      check("R6", "pci fast", 32'(pci_clk_o), (j % 6 < 3) ? 32'h7f : 32'h0);
      check("R6", "pci free fast", 32'(pci_free_o), (j % 6 < 3) ? 32'h1 : 32'h0);
      @(negedge sys_clk);
    end
  endtask

  // R1 R5 R7: 66 MHz state pattern
  task automatic t_slow();
    set_code(3'b011);
    for (int j = 0; j < 12; j++) begin
      check("R5", "cpu slow", 32'(cpu_clk_o), (j % 2 == 0) ? 32'hf : 32'h0);
      check("R7", "pci slow", 32'(pci_clk_o), (j % 4 < 2) ? 32'h7f : 32'h0);
      check("R7", "pci free slow", 32'(pci_free_o), (j % 4 < 2) ? 32'h1 : 32'h0);
      @(negedge sys_clk);
    end
  endtask

  // R11: switching mid-period restarts both dividers high
  task automatic t_restart();
    set_code(3'b111);
    repeat (3) @(negedge sys_clk);
    check("R11", "cpu low before switch", 32'(cpu_clk_o[0]), 32'h0);
    set_code(3'b011);
    check("R11", "cpu after switch", 32'(cpu_clk_o), 32'hf);
    check("R11", "pci after switch", 32'(pci_clk_o), 32'h7f);
    @(negedge sys_clk);
    set_code(3'b111);
    check("R11", "cpu after second switch", 32'(cpu_clk_o[0]), 32'h1);
    check("R11", "pci free after second switch", 32'(pci_free_o), 32'h1);
  endtask

  // R2: quiet code ignores the clock inputs
  task automatic t_quiet();
    set_code(3'b111);
    set_code(3'b000);
    for (int j = 0; j < 4; j++) begin
      tclk_in = j[0]; aux48_in = ~j[0];
      @(negedge sys_clk);
      check("R2", "quiet enables", 32'(oes()), 32'h0);
      check("R2", "quiet clocks", 32'(any_clk()), 32'h0);
    end
    tclk_in = 1'b0; aux48_in = 1'b0;
  endtask

  // R3: each unassigned code acts as quiet
  task automatic t_reserved();
    logic [2:0] rsv [4] = '{3'b001, 3'b010, 3'b101, 3'b110};
    for (int i = 0; i < 4; i++) begin
      set_code(3'b111);
      @(negedge sys_clk);
      set_code(rsv[i]);
      for (int j = 0; j < 3; j++) begin
        tclk_in = ~j[0];
        check("R3", "reserved enables", 32'(oes()), 32'h0);
        check("R3", "reserved clocks", 32'(any_clk()), 32'h0);
        @(negedge sys_clk);
      end
      tclk_in = 1'b0;
    end
  endtask

  // R9 R10: pass-through lines in a running state
  task automatic t_pass();
    set_code(3'b011);
    for (int k = 0; k < 6; k++) begin
      logic a, t;
      a = k[0] ^ k[1];
      t = k[1];
      aux48_in = a; tclk_in = t;
      @(negedge sys_clk);
      check("R10", "usb follows aux", 32'(usb_clk_o), a ? 32'h3 : 32'h0);
      check("R9", "ref follows tclk", 32'(ref_clk_o), t ? 32'h7 : 32'h0);
      check("R9", "apic follows tclk", 32'(apic_clk_o), t ? 32'h3 : 32'h0);
    end
    tclk_in = 1'b0; aux48_in = 1'b0;
    repeat (2) @(negedge sys_clk);
  endtask

  // R8 R9: test state steps on test clock edges
  task automatic t_test();
    set_code(3'b100);
    check("R8", "cpu at entry", 32'(cpu_clk_o), 32'hf);
    check("R8", "pci at entry", 32'(pci_clk_o), 32'h7f);
    check("R8", "usb at entry", 32'(usb_clk_o), 32'h3);
    check("R4", "enables test", 32'(oes()), 32'h1f);
    for (int k = 1; k <= 12; k++) begin
      tclk_in = 1'b1;
      @(negedge sys_clk);
      check("R9", "ref high in test", 32'(ref_clk_o), 32'h7);
      check("R8", "cpu holds before step", 32'(cpu_clk_o[0]), ((k - 1) % 2 == 0) ? 32'h1 : 32'h0);
      @(negedge sys_clk);
      tclk_in = 1'b0;
      repeat (2) @(negedge sys_clk);
      check("R9", "ref low in test", 32'(ref_clk_o), 32'h0);
      check("R8", "cpu div2 test", 32'(cpu_clk_o), (k % 2 == 0) ? 32'hf : 32'h0);
      check("R8", "pci div6 test", 32'(pci_clk_o), (k % 6 < 3) ? 32'h7f : 32'h0);
      check("R8", "usb div2 test", 32'(usb_clk_o), (k % 2 == 0) ? 32'h3 : 32'h0);
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    errs++;
    $display("FAIL R12 watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    @(negedge sys_clk);
    t_reset();
    t_fast();
    t_slow();
    t_restart();
    t_quiet();
    t_reserved();
    t_pass();
    t_test();
    t_quiet();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule